// File: doc/BRIEF.md
# Owner-Side Coherence Transaction Controller

This controller runs at the node that currently holds the primary copy of a set of cache blocks. It serves read, write and upgrade misses from other nodes directly, without a trip through a fixed home node. For every block it holds as owner, it keeps a sharer bit-vector (one bit per node), a busy flag, and a small wrapping version number. A write or upgrade walks the other sharers and sends each one an invalidation. It then waits for the matching number of acknowledgements, grants ownership to the requester, and tells the home node who the new owner is, together with the advanced version.

Requests enter on a valid/ready stream and are never queued. A request that hits a block with a transaction in flight, or a block this node no longer owns, is bounced back to the requester as a retry. Every outgoing message (data copy, grant, invalidation, retry, change-owner report, eviction handoff, writeback) leaves on one valid/ready stream, one message per accepted beat. While a message waits for `out_ready`, every field is held steady and no new request is taken. Acknowledgements and ownership adoption are plain pulses. A block whose ownership moves to this node from elsewhere is installed through the adopt pulse.

Eviction of a primary copy is requested with its own request kind. A block with a transaction in flight refuses eviction. Otherwise the vector and ownership are offered to one sharer, picked from a pseudo-random starting point. If no sharer is left, the block is written back to the home node.

Top module: `oc_owner_ctrl`

## Requirements
- R1: After reset every slot is owned by this node with an empty sharer vector, not busy, version 0; `out_valid` is low and `req_ready` is high.
- R2: A request is taken on a cycle with `req_valid` and `req_ready` both high. While `out_valid` is high and `out_ready` low, all message fields stay stable, `out_valid` stays high, and `req_ready` is low.
- R3: A read (req_kind 0) to an owned, idle slot produces one DATA message (out_kind 1, out_data 1) to the requester and adds the requester to the sharer vector.
- R4: A write (req_kind 1) sends one INV (out_kind 3) to each sharer other than the requester, in ascending node order. It then loads an acknowledgement count equal to the number of INVs. No GRANT (out_kind 2) leaves before that many acks for the slot have arrived. A write GRANT has out_data 1.
- R5: An upgrade (req_kind 2) behaves like a write, except that its GRANT carries out_data 0 if the requester's sharer bit was still set, and out_data 1 if it had been cleared.
- R6: An upgrade whose requester shares the block with exactly one other node sends one INV and is granted right after that single ack. An upgrade or write with no other sharers is granted with no INV.
- R7: Any request to a slot with a transaction in flight gets a NACK (out_kind 4) to the requester and leaves the slot's state unchanged.
- R8: Each GRANT is followed by a change-owner message (out_kind 5) to node HOME_ID. That message carries out_owner equal to the new owner and out_ver equal to the old version plus one, modulo 2^VER_W. After the GRANT the slot is no longer owned, and later requests to it are NACKed.
- R9: An eviction request (req_kind 3) to a busy slot is NACKed to its requester, and the transaction in flight still completes.
- R10: Eviction of an idle slot with sharers sends a HANDOFF (out_kind 6) whose out_dest is a node with its bit set in out_vec. out_vec carries the full sharer vector and out_ver the advanced version. The slot is then not owned.
- R11: Eviction of an idle slot with no sharers sends a writeback (out_kind 7) to HOME_ID, and the slot is then not owned.
- R12: An adopt pulse on an unowned slot makes it owned with the given version, an empty vector and no busy flag. An adopt pulse on an owned slot is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid is also high |
| req_slot | input | SLOT_W | Primary-copy slot addressed |
| req_src | input | NODE_W | Requesting node |
| req_kind | input | 2 | 0 read, 1 write, 2 upgrade, 3 evict |
| ack_valid | input | 1 | One invalidation acknowledgement |
| ack_slot | input | SLOT_W | Slot the acknowledgement belongs to |
| adopt_valid | input | 1 | Ownership of a slot arrives at this node |
| adopt_slot | input | SLOT_W | Slot being adopted |
| adopt_ver | input | VER_W | Version carried with the adopted ownership |
| out_valid | output | 1 | Message present |
| out_ready | input | 1 | Network takes the message |
| out_kind | output | 3 | 1 DATA, 2 GRANT, 3 INV, 4 NACK, 5 change-owner, 6 HANDOFF, 7 writeback |
| out_slot | output | SLOT_W | Slot the message concerns |
| out_dest | output | NODE_W | Destination node |
| out_owner | output | NODE_W | New owner named by change-owner and HANDOFF |
| out_ver | output | VER_W | Version after the transfer |
| out_data | output | 1 | Message carries the block's data |
| out_vec | output | NODES | Sharer vector of the slot (meaningful on HANDOFF) |

## Verification
The bench sweeps every slot through nine ownership transfers. The sweep mixes writes, upgrades whose requester still shares the block, and upgrades whose requester was dropped, and it wraps the version past its top value. A controller that skipped the requester in the INV walk, or counted it, would hang or grant early. One that tested the wrong presence bit would flip out_data on upgrades, and one that advanced the version at the wrong point would report a stale owner to the home node. Requests arriving during an open transaction, acks held back until the last one, eviction of busy, shared and empty slots, and adoption of owned versus unowned slots are each driven explicitly. A design that queued or served a busy request, granted before the final ack, handed off to a non-sharer, or let a stray adopt overwrite a live version would show a wrong message kind, a wrong destination or a wrong version.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    RQ_READ  = 2'd0,
    RQ_WRITE = 2'd1,
    RQ_UPGR  = 2'd2,
    RQ_EVICT = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    MS_NONE  = 3'd0,
    MS_DATA  = 3'd1,
    MS_GRANT = 3'd2,
    MS_INV   = 3'd3,
    MS_NACK  = 3'd4,
    MS_CHOWN = 3'd5,
    MS_HAND  = 3'd6,
    MS_WB    = 3'd7
  } msg_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DATA, ST_NACK, ST_INV, ST_GRANT, ST_CHOWN, ST_HAND, ST_WB
  } eng_state_e;
endpackage

// File: rtl/oc_ack_counter.sv
module oc_ack_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load)              cnt_q <= load_val;
    else if (dec && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R4: an ack arrives only while invalidations are outstanding
  assert_ack_expected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !zero);
endmodule

// File: rtl/oc_sharer_pick.sv
module oc_sharer_pick #(
  parameter int NODES  = 32,
  parameter int NODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODES-1:0]  vec,
  output logic [NODE_W-1:0] pick,
  output logic              found
);
  logic [15:0] lfsr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr_q <= 16'hACE1;
    else        lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
  end

  always_comb begin
    int start;
    start = int'(lfsr_q) % NODES;
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NODES; i++) begin
      int idx;
      idx = (start + i) % NODES;
      if (!found && vec[idx]) begin
        pick  = NODE_W'(idx);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/oc_owner_ctrl.sv
module oc_owner_ctrl
  import oc_pkg::*;
#(
  parameter int NODES   = 32,
  parameter int SLOTS   = 4,
  parameter int VER_W   = 3,
  parameter int HOME_ID = 31,
  localparam int NODE_W = $clog2(NODES),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int CNT_W  = $clog2(NODES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [NODE_W-1:0] req_src,
  input  logic [1:0]        req_kind,
  input  logic              ack_valid,
  input  logic [SLOT_W-1:0] ack_slot,
  input  logic              adopt_valid,
  input  logic [SLOT_W-1:0] adopt_slot,
  input  logic [VER_W-1:0]  adopt_ver,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_kind,
  output logic [SLOT_W-1:0] out_slot,
  output logic [NODE_W-1:0] out_dest,
  output logic [NODE_W-1:0] out_owner,
  output logic [VER_W-1:0]  out_ver,
  output logic              out_data,
  output logic [NODES-1:0]  out_vec
);
  logic [NODES-1:0]  vec_q  [SLOTS];
  logic [VER_W-1:0]  ver_q  [SLOTS];
  logic [NODE_W-1:0] psrc_q [SLOTS];
  logic [SLOTS-1:0]  own_q, busy_q, needd_q;

  eng_state_e        st_q;
  logic [SLOT_W-1:0] cur_slot;
  logic [NODE_W-1:0] cur_src, hand_dest, inv_dest, pick;
  logic [NODES-1:0]  walk_q, others, src_bit;
  logic              pick_found, accept, reject, done_any;
  logic [SLOT_W-1:0] done_slot;
  logic [CNT_W-1:0]  load_val;
  logic [SLOTS-1:0]  cnt_zero, cnt_load, cnt_dec;
  req_kind_e         rkind;

  assign rkind   = req_kind_e'(req_kind);
  assign src_bit = {{(NODES-1){1'b0}}, 1'b1} << req_src;
  assign others  = vec_q[req_slot] & ~src_bit;
  assign reject  = !own_q[req_slot] || busy_q[req_slot];

  // lowest-numbered slot whose acks are all back
  always_comb begin
    done_any  = 1'b0;
    done_slot = '0;
    for (int s = SLOTS - 1; s >= 0; s--)
      if (busy_q[s] && cnt_zero[s]) begin
        done_any  = 1'b1;
        done_slot = SLOT_W'(s);
      end
  end

  assign req_ready = (st_q == ST_IDLE) && !done_any;
  assign accept    = req_valid && req_ready;

  always_comb begin
    int n;
    n = 0;
    for (int i = 0; i < NODES; i++) n += int'(others[i]);
    load_val = CNT_W'(n);
  end

  always_comb begin
    inv_dest = '0;
    for (int i = NODES - 1; i >= 0; i--)
      if (walk_q[i]) inv_dest = NODE_W'(i);
  end

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_cnt
      assign cnt_load[s] = accept && !reject && (req_slot == SLOT_W'(s)) &&
                           (rkind == RQ_WRITE || rkind == RQ_UPGR);
      assign cnt_dec[s]  = ack_valid && (ack_slot == SLOT_W'(s));
      oc_ack_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load[s]), .load_val(load_val),
        .dec(cnt_dec[s]), .zero(cnt_zero[s]));
    end
  endgenerate

  oc_sharer_pick #(.NODES(NODES), .NODE_W(NODE_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .vec(vec_q[req_slot]), .pick(pick), .found(pick_found));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      own_q     <= '1;
      busy_q    <= '0;
      needd_q   <= '0;
      cur_slot  <= '0;
      cur_src   <= '0;
      hand_dest <= '0;
      walk_q    <= '0;
      for (int s = 0; s < SLOTS; s++) begin
        vec_q[s]  <= '0;
        ver_q[s]  <= '0;
        psrc_q[s] <= '0;
      end
    end else begin
      if (adopt_valid && !own_q[adopt_slot]) begin
        own_q[adopt_slot] <= 1'b1;
        ver_q[adopt_slot] <= adopt_ver;
        vec_q[adopt_slot] <= '0;
      end
      unique case (st_q)
        ST_IDLE: begin
          if (done_any) begin
            cur_slot <= done_slot;
            cur_src  <= psrc_q[done_slot];
            st_q     <= ST_GRANT;
          end else if (accept) begin
            cur_slot <= req_slot;
            cur_src  <= req_src;
            if (reject) st_q <= ST_NACK;
            else begin
              unique case (rkind)
                RQ_READ: st_q <= ST_DATA;
                RQ_WRITE, RQ_UPGR: begin
                  busy_q[req_slot]  <= 1'b1;
                  psrc_q[req_slot]  <= req_src;
                  needd_q[req_slot] <= (rkind == RQ_WRITE) || !vec_q[req_slot][req_src];
                  walk_q            <= others;
                  st_q              <= (others != '0) ? ST_INV : ST_IDLE;
                end
                RQ_EVICT: begin
                  hand_dest <= pick;
                  st_q      <= pick_found ? ST_HAND : ST_WB;
                end
              endcase
            end
          end
        end
        ST_DATA: if (out_ready) begin
          vec_q[cur_slot][cur_src] <= 1'b1;
          st_q <= ST_IDLE;
        end
        ST_NACK: if (out_ready) st_q <= ST_IDLE;
        ST_INV: if (out_ready) begin
          walk_q[inv_dest] <= 1'b0;
          if ((walk_q & ~({{(NODES-1){1'b0}}, 1'b1} << inv_dest)) == '0) st_q <= ST_IDLE;
        end
        ST_GRANT: if (out_ready) begin
          own_q[cur_slot]  <= 1'b0;
          busy_q[cur_slot] <= 1'b0;
          vec_q[cur_slot]  <= '0;
          ver_q[cur_slot]  <= ver_q[cur_slot] + 1'b1;
          st_q             <= ST_CHOWN;
        end
        ST_CHOWN: if (out_ready) st_q <= ST_IDLE;
        ST_HAND: if (out_ready) begin
          own_q[cur_slot] <= 1'b0;
          vec_q[cur_slot] <= '0;
          ver_q[cur_slot] <= ver_q[cur_slot] + 1'b1;
          st_q            <= ST_IDLE;
        end
        ST_WB: if (out_ready) begin
          own_q[cur_slot] <= 1'b0;
          st_q            <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    out_valid = (st_q != ST_IDLE);
    out_slot  = cur_slot;
    out_vec   = vec_q[cur_slot];
    out_owner = (st_q == ST_HAND) ? hand_dest : cur_src;
    out_ver   = ver_q[cur_slot] + VER_W'((st_q == ST_GRANT) || (st_q == ST_HAND));
    out_data  = 1'b0;
    out_dest  = cur_src;
    out_kind  = MS_NONE;
    unique case (st_q)
      ST_DATA:  begin out_kind = MS_DATA;  out_data = 1'b1; end
      ST_NACK:  out_kind = MS_NACK;
      ST_INV:   begin out_kind = MS_INV;   out_dest = inv_dest; end
      ST_GRANT: begin out_kind = MS_GRANT; out_data = needd_q[cur_slot]; end
      ST_CHOWN: begin out_kind = MS_CHOWN; out_dest = NODE_W'(HOME_ID); end
      ST_HAND:  begin out_kind = MS_HAND;  out_dest = hand_dest; end
      ST_WB:    begin out_kind = MS_WB;    out_dest = NODE_W'(HOME_ID); end
      default:  out_kind = MS_NONE;
    endcase
  end

  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_dest) && $stable(out_slot));

  assert_grant_after_acks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == MS_GRANT |-> cnt_zero[out_slot]);

  assert_busy_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && busy_q[req_slot] |=> out_valid && out_kind == MS_NACK);

  assert_handoff_sharer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == MS_HAND |-> out_vec[out_dest]);
endmodule

// File: tb/oc_owner_ctrl_test.sv
module oc_owner_ctrl_test;
  localparam int HOME = 31;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, ack_valid = 0, adopt_valid = 0, out_ready = 0;
  logic [1:0] req_slot = 0, ack_slot = 0, adopt_slot = 0, req_kind = 0, out_slot;
  logic [4:0] req_src = 0, out_dest, out_owner;
  logic [2:0] adopt_ver = 0, out_kind, out_ver;
  logic req_ready, out_valid, out_data;
  logic [31:0] out_vec;
  int total = 0, bad = 0;
  bit finished = 0;
  int mk, md, mo, mv, mdt;
  logic [31:0] mvec;

  always #4 clk = ~clk;

  oc_owner_ctrl uut (.*);

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (3) @(posedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic send(int slot, int src, int kind);
    @(negedge clk);
    req_slot = 2'(slot); req_src = 5'(src); req_kind = 2'(kind); req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 0;
  endtask

  task automatic recv();
    out_ready = 1;
    while (!out_valid) @(negedge clk);
    mk = out_kind; md = out_dest; mo = out_owner; mv = out_ver; mdt = out_data; mvec = out_vec;
    @(negedge clk); out_ready = 0;
  endtask

  task automatic ack(int slot);
    @(negedge clk); ack_valid = 1; ack_slot = 2'(slot);
    @(negedge clk); ack_valid = 0;
  endtask

  task automatic adopt(int slot, int ver);
    @(negedge clk); adopt_valid = 1; adopt_slot = 2'(slot); adopt_ver = 3'(ver);
    @(negedge clk); adopt_valid = 0;
  endtask

  task automatic quiet(string tag);
    repeat (3) begin @(negedge clk); chk(tag, int'(out_valid), 0); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ev [4];
    do_reset();
    @(negedge clk);
    chk("R1 ready after reset", int'(req_ready), 1);
    chk("R1 out_valid after reset", int'(out_valid), 0);
    for (int s = 0; s < 4; s++) ev[s] = 0;

    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 9; p++) begin
        logic [31:0] mask, oth;
        int w, mode, cnt, nx;
        w = ((p * 13 + s * 5) % 29) + 1;
        mode = p % 3;
        mask = '0;
        for (int n = 1; n < 31; n++) if ((n + p + s) % 7 == 0) mask[n] = 1;
        if (mode == 1) mask[w] = 1;
        if (mode == 2) mask[w] = 0;
        for (int n = 0; n < 32; n++) if (mask[n]) begin
          send(s, n, 0); recv();
          chk("R3 read kind", mk, 1); chk("R3 read dest", md, n); chk("R3 read data", mdt, 1);
        end
        send(s, w, (mode == 0) ? 1 : 2);
        oth = mask; oth[w] = 0; cnt = 0;
        for (int n = 0; n < 32; n++) if (oth[n]) begin
          recv(); cnt++;
          chk("R4 inv kind", mk, 3); chk("R4 inv order dest", md, n);
        end
        if (cnt > 0) begin
          nx = (w == 30) ? 29 : 30;
          send(s, nx, 0); recv();
          chk("R7 busy kind", mk, 4); chk("R7 busy dest", md, nx);
          for (int a = 0; a < cnt - 1; a++) ack(s);
          quiet("R4 no grant before last ack");
          ack(s);
        end
        recv();
        chk("R4 grant kind", mk, 2); chk("R4 grant dest", md, w);
        chk("R5 grant data", mdt, (mode == 1) ? 0 : 1);
        ev[s] = (ev[s] + 1) % 8;
        chk("R8 grant ver", mv, ev[s]);
        recv();
        chk("R8 chown kind", mk, 5); chk("R8 chown dest", md, HOME);
        chk("R8 chown owner", mo, w); chk("R8 chown ver", mv, ev[s]);
        send(s, 3, 0); recv();
        chk("R8 unowned nack", mk, 4);
        adopt(s, ev[s]);
        adopt(s, (ev[s] + 3) % 8);  // R12: ignored, slot already owned
      end

    // R12 adopted slot with no sharers: immediate grant, version from adopt
    send(1, 8, 1); recv();
    chk("R12 adopt grant kind", mk, 2);
    chk("R12 adopt version", mv, (ev[1] + 1) % 8);
    recv(); chk("R12 chown", mk, 5);

    // R6 upgrade with exactly one other sharer
    do_reset();
    send(2, 4, 0); recv(); send(2, 9, 0); recv();
    send(2, 9, 2); recv();
    chk("R6 single inv kind", mk, 3); chk("R6 single inv dest", md, 4);
    quiet("R6 waits for ack");
    ack(2); recv();
    chk("R6 grant kind", mk, 2); chk("R6 grant data", mdt, 0); chk("R6 grant ver", mv, 1);
    recv(); chk("R6 chown", mk, 5);

    // R2 back-pressure during the invalidation walk
    send(0, 3, 0); recv(); send(0, 6, 0); recv();
    send(0, 10, 1);
    repeat (3) begin
      @(negedge clk);
      chk("R2 held valid", int'(out_valid), 1);
      chk("R2 held dest", int'(out_dest), 3);
      chk("R2 ready low", int'(req_ready), 0);
    end
    recv(); chk("R2 first inv", md, 3);
    recv(); chk("R2 second inv", md, 6);
    ack(0); ack(0); recv(); chk("R2 grant", mk, 2); recv();

    // R9 evict of busy slot
    do_reset();
    send(2, 7, 0); recv();
    send(2, 12, 1); recv(); chk("R9 inv", md, 7);
    send(2, 0, 3); recv();
    chk("R9 evict busy kind", mk, 4); chk("R9 evict busy dest", md, 0);
    ack(2); recv(); chk("R9 grant completes", mk, 2); recv();

    // R10 evict with sharers
    send(0, 5, 0); recv(); send(0, 9, 0); recv();
    send(0, 0, 3); recv();
    chk("R10 handoff kind", mk, 6);
    chk("R10 handoff target is sharer", int'(md == 5 || md == 9), 1);
    chk("R10 handoff vec", int'(mvec == 32'h0000_0220), 1);
    chk("R10 handoff ver", mv, 1);
    send(0, 5, 0); recv(); chk("R10 unowned after handoff", mk, 4);

    // R11 evict with no sharers
    send(1, 0, 3); recv();
    chk("R11 wb kind", mk, 7); chk("R11 wb dest", md, HOME);
    send(1, 2, 0); recv(); chk("R11 unowned after wb", mk, 4);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule